// File: doc/BRIEF.md
# Crystal Clock Failure Monitor

This block checks that a fast crystal oscillator clock is still toggling. It compares it with a slow RC reference clock that always runs. A small counter in the fast domain counts crystal edges while the reference clock is high. The counter is held at zero while the reference clock is low, and it stops counting once it reaches a fixed minimum. Logic on the reference clock samples the counter on each falling edge and passes the result through a two-stage pipeline. If a window held fewer edges than the minimum, it reports a failure.

The result drives four things:
- a live status bit;
- a sticky event flag, which clears when the status register is read;
- an interrupt, which can be masked;
- a latched fault output for protection logic downstream, which only an explicit clear strobe can drop.

The monitor runs only when software enables it and the crystal oscillator is switched on.

Top module: `xtal_fail_mon`

## Requirements
- R1: While `rst_n` is low and after its release, `fail_status`, `evt_flag`, `irq` and `fault_out` are 0, and the monitor is inactive.
- R2: The monitor is active only while both `cfd_en` and `xtal_on` were 1 at the last rising edge of `slow_clk`. While it is inactive, `fail_status` is 0 and no new event or fault can arise.
- R3: The counting window is the high phase of `slow_clk`. Rising edges of `fast_clk` in that window are counted, and the count saturates at `MIN_EDGES` (default 8). A window with at least `MIN_EDGES` edges passes and a window with fewer fails, so a 60 ns crystal period passes and a 75 ns period fails against a 1000 ns reference period.
- R4: After activation, `fail_status` stays 0 through the first falling edge of `slow_clk`. From the second falling edge on, it shows the verdict of the window that ended one falling edge earlier. A short window therefore raises `fail_status` at the second falling edge after it begins, and a good window clears `fail_status` at that same point.
- R5: `evt_flag` is set at the rising edge of `slow_clk` that sees `fail_status` go from 0 to 1. It is cleared at a rising edge where `stat_rd` is 1, but a set in the same cycle takes priority. While a failure persists and no new 0-to-1 change occurs, a read clears the flag.
- R6: `irq` is 1 exactly when `evt_flag` is 1 and `irq_mask` is 0.
- R7: `fault_out` is set at the rising edge of `slow_clk` that sees `fail_status` high. A `fault_clr` pulse drops it only if `fail_status` is 0. A clear pulse given while the failure persists has no effect.
- R8: Once set, `fault_out` stays set when the crystal clock recovers and when the monitor is disabled, until a clear pulse drops it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Free-running RC reference clock; its high phase is the counting window |
| fast_clk | input | 1 | Monitored crystal oscillator clock |
| cfd_en | input | 1 | Software enable of the monitor |
| xtal_on | input | 1 | Crystal oscillator is switched on |
| stat_rd | input | 1 | Status register read strobe, one `slow_clk` cycle |
| fault_clr | input | 1 | Write-one-to-clear strobe for the fault output |
| irq_mask | input | 1 | 1 suppresses the interrupt |
| fail_status | output | 1 | Live verdict: 1 while the crystal is judged failed |
| evt_flag | output | 1 | Sticky failure event flag, cleared by read |
| irq | output | 1 | Interrupt request |
| fault_out | output | 1 | Latched fault line for downstream protection |

## Verification
The assertions assume that `cfd_en`, `xtal_on`, `stat_rd`, `fault_clr` and `irq_mask` are synchronous to the rising edge of `slow_clk`, and that `fast_clk` never has a pulse narrower than the counter can follow. The saturation check also assumes the counter's clear is released only at the start of a window. The bench changes every control input three quarters of the way through a reference period, well away from both clock edges. It starts and stops the crystal clock at that same point, so each window is either wholly running or wholly stopped. The crystal periods it uses sit clearly on either side of the edge-count threshold.

// File: rtl/xtal_fail_mon.sv
module xtal_fail_mon #(
  parameter int MIN_EDGES = 8
) (
  input  logic rst_n,
  input  logic slow_clk,
  input  logic fast_clk,
  input  logic cfd_en,
  input  logic xtal_on,
  input  logic stat_rd,
  input  logic fault_clr,
  input  logic irq_mask,
  output logic fail_status,
  output logic evt_flag,
  output logic irq,
  output logic fault_out
);
  localparam int CW = $clog2(MIN_EDGES + 1);
  localparam logic [CW-1:0] FULL = CW'(MIN_EDGES);

  logic          active_q;
  logic          ph_rise_q, ph_fall_q;
  logic          full_s1_q, full_s2_q;
  logic [1:0]    warm_q;
  logic          fail_prev_q, evt_q, fault_q;
  logic [CW-1:0] cnt_q;

  // window is open between a rising edge and the following falling edge
  wire win_open  = ph_rise_q ^ ph_fall_q;
  wire cnt_run_n = rst_n & active_q & win_open;
  wire fail_now  = active_q & (warm_q == 2'd2) & ~full_s2_q;

  always_ff @(posedge fast_clk or negedge cnt_run_n)
    if (!cnt_run_n)         cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge slow_clk or negedge rst_n)
    if (!rst_n) begin
      active_q    <= 1'b0;
      ph_rise_q   <= 1'b0;
      fail_prev_q <= 1'b0;
      evt_q       <= 1'b0;
      fault_q     <= 1'b0;
    end else begin
      active_q    <= cfd_en & xtal_on;
      ph_rise_q   <= ~ph_rise_q;
      fail_prev_q <= fail_now;
      if (fail_now & ~fail_prev_q) evt_q <= 1'b1;
      else if (stat_rd)            evt_q <= 1'b0;
      if (fail_now)                fault_q <= 1'b1;
      else if (fault_clr)          fault_q <= 1'b0;
    end

  always_ff @(negedge slow_clk or negedge rst_n)
    if (!rst_n) begin
      ph_fall_q <= 1'b0;
      full_s1_q <= 1'b0;
      full_s2_q <= 1'b0;
      warm_q    <= 2'd0;
    end else begin
      ph_fall_q <= ph_rise_q;
      full_s1_q <= (cnt_q == FULL);
      full_s2_q <= full_s1_q;
      if (!active_q)            warm_q <= 2'd0;
      else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

  assign fail_status = fail_now;
  assign evt_flag    = evt_q;
  assign irq         = evt_q & ~irq_mask;
  assign fault_out   = fault_q;
endmodule

module xtal_fail_mon_chk #(
  parameter int MIN_EDGES = 8
) (
  input logic rst_n,
  input logic slow_clk,
  input logic fast_clk,
  input logic cfd_en,
  input logic xtal_on,
  input logic stat_rd,
  input logic fault_clr,
  input logic fail_status,
  input logic evt_flag,
  input logic fault_out,
  input logic [$clog2(MIN_EDGES + 1)-1:0] cnt_q
);
  p_off_quiet_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !(cfd_en && xtal_on) |=> !fail_status);

  p_cnt_sat_r3: assert property (@(posedge fast_clk) disable iff (!rst_n)
    cnt_q <= ($clog2(MIN_EDGES + 1))'(MIN_EDGES));

  p_evt_cause_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(evt_flag) |-> $past(fail_status));

  p_evt_clear_r5: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $fell(evt_flag) |-> $past(stat_rd));

  p_fault_cause_r7: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(fault_out) |-> $past(fail_status));

  p_fault_hold_r8: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $fell(fault_out) |-> ($past(fault_clr) && !$past(fail_status)));
endmodule

bind xtal_fail_mon xtal_fail_mon_chk #(.MIN_EDGES(MIN_EDGES)) u_chk (
  .rst_n(rst_n), .slow_clk(slow_clk), .fast_clk(fast_clk),
  .cfd_en(cfd_en), .xtal_on(xtal_on), .stat_rd(stat_rd),
  .fault_clr(fault_clr), .fail_status(fail_status),
  .evt_flag(evt_flag), .fault_out(fault_out), .cnt_q(cnt_q)
);

// File: tb/xtal_fail_mon_bench.sv
`timescale 1ns/1ps
module xtal_fail_mon_bench;
  localparam int SLOW_PERIOD = 1000;

  logic rst_n = 1'b0, slow_clk = 1'b0, fast_clk = 1'b0;
  logic cfd_en = 1'b0, xtal_on = 1'b0, stat_rd = 1'b0, fault_clr = 1'b0, irq_mask = 1'b0;
  logic fail_status, evt_flag, irq, fault_out;
  logic fast_run = 1'b1;
  int   fast_half = 20;
  int   nchk = 0, nfail = 0;
  bit   done = 1'b0;

  xtal_fail_mon u_xtal_fail_mon (
    .rst_n(rst_n), .slow_clk(slow_clk), .fast_clk(fast_clk),
    .cfd_en(cfd_en), .xtal_on(xtal_on), .stat_rd(stat_rd),
    .fault_clr(fault_clr), .irq_mask(irq_mask),
    .fail_status(fail_status), .evt_flag(evt_flag), .irq(irq), .fault_out(fault_out)
  );

  always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;
  always begin
    #(fast_half);
    if (fast_run) fast_clk = ~fast_clk;
  end

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // advance to three quarters into a later slow period
  task automatic tick(int n);
    repeat (n) @(negedge slow_clk);
    #(SLOW_PERIOD/4);
  endtask

  task automatic pulse_rd();
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
  endtask

  task automatic pulse_clr();
    fault_clr = 1'b1; tick(1); fault_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", fail_status, 1'b0);
    chk("R1 flag", evt_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    chk("R1 fault", fault_out, 1'b0);
  endtask

  task automatic t_gated();
    fast_run = 1'b0;
    tick(5);
    chk("R2 disabled status", fail_status, 1'b0);
    chk("R2 disabled fault", fault_out, 1'b0);
    cfd_en = 1'b1;
    tick(5);
    chk("R2 xtal off status", fail_status, 1'b0);
    chk("R2 xtal off flag", evt_flag, 1'b0);
    xtal_on = 1'b1;
    tick(1);
    chk("R4 warm-up first fall", fail_status, 1'b0);
    tick(1);
    chk("R4 verdict second fall", fail_status, 1'b1);
    cfd_en = 1'b0;
    tick(1);
    chk("R2 disable drops status", fail_status, 1'b0);
    chk("R8 fault kept when disabled", fault_out, 1'b1);
    fast_run = 1'b1;
    pulse_clr();
    pulse_rd();
    chk("R7 clear when healthy", fault_out, 1'b0);
    chk("R5 read clears", evt_flag, 1'b0);
    cfd_en = 1'b1;
    tick(6);
    chk("R3 healthy 40ns", fail_status, 1'b0);
    chk("R3 healthy no fault", fault_out, 1'b0);
  endtask

  task automatic t_stop();
    fast_run = 1'b0;
    tick(1);
    chk("R4 one fall after stop", fail_status, 1'b0);
    tick(1);
    chk("R4 two falls after stop", fail_status, 1'b1);
    chk("R5 flag not yet", evt_flag, 1'b0);
    tick(1);
    chk("R5 flag set", evt_flag, 1'b1);
    chk("R6 irq unmasked", irq, 1'b1);
    chk("R7 fault set", fault_out, 1'b1);
    pulse_clr();
    chk("R7 clear ignored while failing", fault_out, 1'b1);
    pulse_rd();
    chk("R5 read clears during failure", evt_flag, 1'b0);
    chk("R6 irq follows flag", irq, 1'b0);
    chk("R4 status persists", fail_status, 1'b1);
    fast_run = 1'b1;
    tick(1);
    chk("R4 still failed one fall after restart", fail_status, 1'b1);
    tick(1);
    chk("R4 recovered", fail_status, 1'b0);
    tick(2);
    chk("R8 fault kept after recovery", fault_out, 1'b1);
    chk("R5 no new event on recovery", evt_flag, 1'b0);
    pulse_clr();
    chk("R7 clear after recovery", fault_out, 1'b0);
  endtask

  task automatic t_masked();
    irq_mask = 1'b1;
    fast_run = 1'b0;
    tick(3);
    chk("R6 masked flag", evt_flag, 1'b1);
    chk("R6 masked irq", irq, 1'b0);
    irq_mask = 1'b0;
    #1;
    chk("R6 unmask raises irq", irq, 1'b1);
    pulse_rd();
    fast_run = 1'b1;
    tick(3);
    pulse_clr();
    chk("R6 irq low after read", irq, 1'b0);
  endtask

  task automatic t_priority();
    fast_run = 1'b0;
    for (int i = 0; i < 8 && !fail_status; i++) tick(1);
    chk("R4 failure seen", fail_status, 1'b1);
    pulse_rd();
    chk("R5 set beats read", evt_flag, 1'b1);
    pulse_rd();
    chk("R5 later read clears", evt_flag, 1'b0);
    fast_run = 1'b1;
    tick(3);
    pulse_clr();
  endtask

  task automatic t_threshold();
    fast_half = 30;
    tick(6);
    chk("R3 60ns passes", fail_status, 1'b0);
    chk("R3 60ns no event", evt_flag, 1'b0);
    fast_half = 37;
    tick(4);
    chk("R3 74ns fails", fail_status, 1'b1);
    chk("R3 74ns fault", fault_out, 1'b1);
    fast_half = 20;
    tick(4);
    chk("R3 back to healthy", fail_status, 1'b0);
    pulse_rd();
    pulse_clr();
    chk("R7 final clear", fault_out, 1'b0);
  endtask

  initial begin
    #(SLOW_PERIOD * 300);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_gated();
    t_stop();
    t_masked();
    t_priority();
    t_threshold();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule